// File: doc/BRIEF.md
# Module Idle Request Handshake

This wrapper sits between software's per-module enable field and one peripheral. It turns the enable into an idle request toward the module and reports, through a 2-bit status, how far the module has got in entering or leaving idle. The clock-domain controller reads this status and the functional-clock request to decide when the domain may sleep. Any request the module has not acknowledged shows as a lasting "transitioning" status, so a domain can never gate a clock under a module that is still working.

A selectable idle mode sets how the module answers an idle request. It can acknowledge at once, it can refuse forever, or it can acknowledge once its internal busy flag drops. Leaving idle needs the module to be out of reset: while the module reset is asserted, the wake sequence stalls in the transitioning state. After an acknowledged idle request the module keeps its interface enabled for a fixed number of cycles, and only then reports full disable and drops its functional-clock request.

Top module: `idle_handshake`

## Requirements
- R1: While rst_ni is low, and after it is released, the block is disabled until the enable changes: status 3, idle request 1, functional-clock request 0.
- R2: With the module functional (status 0), a mode_i of 0 gives status 1 (transitioning) with the idle request at 1 one clock later.
- R3: With idle_mode_i = 0 (force), a pending enter-idle request is acknowledged at the next clock. The status then reads 2 (idle, interface still on) for IFACE_HOLD cycles, then 3.
- R4: With idle_mode_i = 2 (smart), the status stays 1 while busy_i is 1. It moves to 2 on the first clock where busy_i is 0.
- R5: With idle_mode_i = 1 or 3 (no-idle), an enter-idle request is never acknowledged, and the status stays 1 as long as mode_i stays 0.
- R6: A nonzero mode_i (1, 2 or 3 all mean enabled) from status 3 gives status 1, idle request 0 and functional-clock request 1 one clock later. The status becomes 0 at the clock where mod_rst_i is seen low.
- R7: While mod_rst_i is 1 during a wake, the status stays 1 for as long as the reset lasts.
- R8: The functional-clock request is 0 exactly when the status is 3, and is 1 in every other status.
- R9: A change of mode_i while a transition or the interface hold is in progress redirects the sequence at the next clock. A nonzero mode_i during an enter-idle request or the hold goes to the wake state, even if an acknowledge would be given in the same cycle. A zero mode_i during a wake goes to the enter-idle state.
- R10: The idle request is 0 when the status is 0, and also during a wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | MODE_W | Module enable from software; 0 disables |
| idle_mode_i | input | 2 | 0 force, 1 no-idle, 2 smart, 3 no-idle |
| busy_i | input | 1 | Module busy flag, used by smart idle |
| mod_rst_i | input | 1 | Module is held in reset |
| idle_req_o | output | 1 | Idle request toward the module |
| idle_st_o | output | 2 | 0 functional, 1 transitioning, 2 idle with interface, 3 disabled |
| fclk_req_o | output | 1 | Functional-clock request to the domain controller |

## Verification
The enable is dropped under each idle mode: force, smart with busy held high for several cycles, and both no-idle codes held for many cycles. This separates an immediate acknowledge from a gated one and from a refusal. Wakes are run with the module reset held and released, which separates a stall caused by reset from an ordinary one-cycle wake. Redirects are also applied in the enter-idle state, in the interface hold and in the wake state, and these show that a new enable beats a same-cycle acknowledge.

// File: rtl/idle_hs_pkg.sv
package idle_hs_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_ENTER = 3'd1,
    ST_IFACE = 3'd2,
    ST_OFF   = 3'd3,
    ST_EXIT  = 3'd4
  } hs_state_e;

  localparam logic [1:0] IM_FORCE  = 2'd0;
  localparam logic [1:0] IM_NOIDLE = 2'd1;
  localparam logic [1:0] IM_SMART  = 2'd2;

  localparam logic [1:0] STAT_FUNC  = 2'd0;
  localparam logic [1:0] STAT_TRANS = 2'd1;
  localparam logic [1:0] STAT_IFACE = 2'd2;
  localparam logic [1:0] STAT_OFF   = 2'd3;
endpackage

// File: rtl/idle_ack_gen.sv
module idle_ack_gen (
  input  logic [1:0] idle_mode_i,
  input  logic       busy_i,
  output logic       ack_o
);
  import idle_hs_pkg::*;

  always_comb begin
    unique case (idle_mode_i)
      IM_FORCE: ack_o = 1'b1;
      IM_SMART: ack_o = ~busy_i;
      default:  ack_o = 1'b0;   // no-idle codes
    endcase
  end
endmodule

// File: rtl/idle_hs_fsm.sv
module idle_hs_fsm
  import idle_hs_pkg::*;
#(
  parameter int MODE_W     = 2,
  parameter int IFACE_HOLD = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ack_i,
  input  logic              mod_rst_i,
  output hs_state_e         state_o
);
  localparam int CNT_W = $clog2(IFACE_HOLD + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IFACE_HOLD - 1);

  hs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign en = (mode_i != '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    unique case (state_q)
      ST_RUN:   if (!en) state_d = ST_ENTER;
      ST_ENTER: begin
        if (en)         state_d = ST_EXIT;  // enable beats acknowledge
        else if (ack_i) state_d = ST_IFACE;
      end
      ST_IFACE: begin
        if (en)                     state_d = ST_EXIT;
        else if (cnt_q == CNT_LAST) state_d = ST_OFF;
        else                        cnt_d   = cnt_q + 1'b1;
      end
      ST_OFF:   if (en) state_d = ST_EXIT;
      ST_EXIT: begin
        if (!en)            state_d = ST_ENTER;
        else if (!mod_rst_i) state_d = ST_RUN;
      end
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  a_r2_run_to_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !en) |=> (state_q == ST_ENTER));
  a_r5_hold_unacked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTER && !en && !ack_i) |=> (state_q == ST_ENTER));
  a_r7_reset_stalls_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXIT && en && mod_rst_i) |=> (state_q == ST_EXIT));
  a_r9_enable_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ENTER || state_q == ST_IFACE) && en) |=> (state_q == ST_EXIT));
  a_r3_hold_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IFACE) |-> (cnt_q <= CNT_LAST));
endmodule

// File: rtl/idle_status_enc.sv
module idle_status_enc
  import idle_hs_pkg::*;
(
  input  hs_state_e  state_i,
  output logic       idle_req_o,
  output logic [1:0] idle_st_o,
  output logic       fclk_req_o
);
  always_comb begin
    idle_req_o = 1'b1;
    fclk_req_o = 1'b1;
    idle_st_o  = STAT_TRANS;
    unique case (state_i)
      ST_RUN: begin
        idle_req_o = 1'b0;
        idle_st_o  = STAT_FUNC;
      end
      ST_ENTER: idle_st_o = STAT_TRANS;
      ST_IFACE: idle_st_o = STAT_IFACE;
      ST_OFF: begin
        idle_st_o  = STAT_OFF;
        fclk_req_o = 1'b0;
      end
      ST_EXIT: idle_req_o = 1'b0;
      default: idle_st_o = STAT_TRANS;
    endcase
  end
endmodule

// File: rtl/idle_handshake.sv
module idle_handshake #(
  parameter int MODE_W     = 2,
  parameter int IFACE_HOLD = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [1:0]        idle_mode_i,
  input  logic              busy_i,
  input  logic              mod_rst_i,
  output logic              idle_req_o,
  output logic [1:0]        idle_st_o,
  output logic              fclk_req_o
);
  import idle_hs_pkg::*;

  logic      ack;
  hs_state_e state;

  idle_ack_gen i_ack (
    .idle_mode_i (idle_mode_i),
    .busy_i      (busy_i),
    .ack_o       (ack)
  );

  idle_hs_fsm #(
    .MODE_W     (MODE_W),
    .IFACE_HOLD (IFACE_HOLD)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .ack_i     (ack),
    .mod_rst_i (mod_rst_i),
    .state_o   (state)
  );

  idle_status_enc i_enc (
    .state_i    (state),
    .idle_req_o (idle_req_o),
    .idle_st_o  (idle_st_o),
    .fclk_req_o (fclk_req_o)
  );

  a_r8_fclk_vs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fclk_req_o == (idle_st_o != STAT_OFF)));
  a_r10_no_req_when_func: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_st_o == STAT_FUNC) |-> !idle_req_o);
  a_r6_wake_raises_fclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_st_o == STAT_OFF && mode_i != '0) |=> (fclk_req_o && !idle_req_o));
  a_r4_smart_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_st_o == STAT_TRANS && idle_req_o && mode_i == '0 && idle_mode_i == IM_SMART && busy_i)
      |=> (idle_st_o == STAT_TRANS));
endmodule

// File: tb/test_idle_handshake.sv
module test_idle_handshake;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = '0;
  logic [1:0] idle_mode_i = '0;
  logic       busy_i = 1'b0;
  logic       mod_rst_i = 1'b0;
  logic       idle_req_o;
  logic [1:0] idle_st_o;
  logic       fclk_req_o;

  always #2.5 clk_i = ~clk_i;

  idle_handshake #(.MODE_W(2), .IFACE_HOLD(2)) i_idle_handshake (
    .clk_i, .rst_ni, .mode_i, .idle_mode_i, .busy_i, .mod_rst_i,
    .idle_req_o, .idle_st_o, .fclk_req_o
  );

  typedef struct {
    logic [1:0] st;
    logic       req;
    logic       fclk;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  task automatic compare(input logic [1:0] st, input logic req, input logic fclk, input string tag);
    checks++;
    if (idle_st_o !== st || idle_req_o !== req || fclk_req_o !== fclk) begin
      errors++;
      $display("FAIL %s: st/req/fclk actual %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, idle_st_o, idle_req_o, fclk_req_o, st, req, fclk);
    end
  endtask

  // state shorthands: 0 run, 1 enter, 2 iface, 3 off, 4 exit
  task automatic step(input logic [1:0] m, input logic [1:0] im, input logic b,
                      input logic mr, input int s, input string tag);
    exp_t e;
    @(negedge clk_i);
    mode_i = m; idle_mode_i = im; busy_i = b; mod_rst_i = mr;
    case (s)
      0: begin e.st = 2'd0; e.req = 1'b0; e.fclk = 1'b1; end
      1: begin e.st = 2'd1; e.req = 1'b1; e.fclk = 1'b1; end
      2: begin e.st = 2'd2; e.req = 1'b1; e.fclk = 1'b1; end
      3: begin e.st = 2'd3; e.req = 1'b1; e.fclk = 1'b0; end
      default: begin e.st = 2'd1; e.req = 1'b0; e.fclk = 1'b1; end
    endcase
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(posedge clk_i) begin
    #1;
    if (rst_ni && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      compare(e.st, e.req, e.fclk, e.tag);
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    #12;
    compare(2'd3, 1'b1, 1'b0, "R1 in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    step(2'd0, 2'd0, 1'b0, 1'b1, 3, "R1 after reset");
    // wake with module reset held
    step(2'd1, 2'd0, 1'b0, 1'b1, 4, "R6 wake");
    step(2'd1, 2'd0, 1'b0, 1'b1, 4, "R7 reset stall");
    step(2'd1, 2'd0, 1'b0, 1'b1, 4, "R7 reset stall");
    step(2'd1, 2'd0, 1'b0, 1'b0, 0, "R6 reset released");
    step(2'd2, 2'd0, 1'b0, 1'b0, 0, "R6 mode 2 enabled");
    // force idle
    step(2'd0, 2'd0, 1'b0, 1'b0, 1, "R2 enter");
    step(2'd0, 2'd0, 1'b0, 1'b0, 2, "R3 force ack");
    step(2'd0, 2'd0, 1'b0, 1'b0, 2, "R3 iface hold");
    step(2'd0, 2'd0, 1'b0, 1'b0, 3, "R8 off");
    step(2'd3, 2'd0, 1'b0, 1'b0, 4, "R8 fclk up");
    step(2'd3, 2'd0, 1'b0, 1'b0, 0, "R10 run");
    // smart idle
    step(2'd0, 2'd2, 1'b1, 1'b0, 1, "R4 enter");
    step(2'd0, 2'd2, 1'b1, 1'b0, 1, "R4 busy");
    step(2'd0, 2'd2, 1'b1, 1'b0, 1, "R4 busy");
    step(2'd0, 2'd2, 1'b0, 1'b0, 2, "R4 idle");
    step(2'd0, 2'd2, 1'b0, 1'b0, 2, "R3 hold");
    step(2'd0, 2'd2, 1'b0, 1'b0, 3, "R3 off");
    // no-idle
    step(2'd1, 2'd1, 1'b0, 1'b0, 4, "R6 wake");
    step(2'd1, 2'd1, 1'b0, 1'b0, 0, "R6 run");
    step(2'd0, 2'd1, 1'b0, 1'b0, 1, "R5 enter");
    for (int i = 0; i < 6; i++) step(2'd0, 2'd1, 1'b0, 1'b0, 1, "R5 no ack");
    step(2'd0, 2'd3, 1'b0, 1'b0, 1, "R5 code 3");
    step(2'd0, 2'd3, 1'b0, 1'b0, 1, "R5 code 3");
    // redirects
    step(2'd1, 2'd3, 1'b0, 1'b1, 4, "R9 abort enter");
    step(2'd1, 2'd3, 1'b0, 1'b1, 4, "R7 stall");
    step(2'd1, 2'd0, 1'b0, 1'b0, 0, "R6 run");
    step(2'd0, 2'd0, 1'b0, 1'b0, 1, "R2 enter");
    step(2'd2, 2'd0, 1'b0, 1'b0, 4, "R9 enable beats ack");
    step(2'd2, 2'd0, 1'b0, 1'b0, 0, "R6 run");
    step(2'd0, 2'd0, 1'b0, 1'b0, 1, "R2 enter");
    step(2'd0, 2'd0, 1'b0, 1'b0, 2, "R3 ack");
    step(2'd1, 2'd0, 1'b0, 1'b0, 4, "R9 abort hold");
    step(2'd1, 2'd0, 1'b0, 1'b0, 0, "R6 run");
    step(2'd0, 2'd0, 1'b0, 1'b0, 1, "R2 enter");
    step(2'd0, 2'd0, 1'b0, 1'b0, 2, "R3 ack");
    step(2'd0, 2'd0, 1'b0, 1'b0, 2, "R3 hold");
    step(2'd0, 2'd0, 1'b0, 1'b0, 3, "R3 off");
    step(2'd1, 2'd0, 1'b0, 1'b1, 4, "R6 wake");
    step(2'd0, 2'd0, 1'b0, 1'b1, 1, "R9 wake withdrawn");
    step(2'd0, 2'd0, 1'b0, 1'b1, 2, "R3 ack");
    @(posedge clk_i); #2;
    @(posedge clk_i); #2;
    report();
  end
endmodule